// File: doc/BRIEF.md
# Banked-Accumulator Subtract Execution Unit

This unit carries out the subtract-from-register operation of an 8-bit processor datapath. When it receives an operation strobe, it reads a source register through a read port it addresses itself. It then computes that register's value minus the currently active accumulator and registers the difference. The difference goes either to a destination register-file entry or to data memory at the address held in a 16-bit index pointer. In the memory case the pointer advances by one afterwards. The unit also produces negative, zero, carry and overflow flags for every operation.

Two accumulators are held inside, one for each register bank, and a bank-exchange command switches which one is active. The active accumulator can be loaded with a constant, and the index pointer can be loaded directly. These loads let the surrounding decode logic set up operands. Instruction fetch, decode and all other ALU operations live outside this block.

Top module: `bsub_exec_unit`

## Requirements
- R1: When `op_go_i` is sampled high with `dst_mem_i` low, one cycle later `rf_we_o` pulses for one cycle, with `rf_waddr_o` equal to the sampled `dst_sel_i` and `rf_wdata_o` equal to (source register − active accumulator) mod 256.
- R2: When `op_go_i` is sampled high with `dst_mem_i` high, one cycle later `mem_we_o` pulses with `mem_addr_o` equal to the pre-operation index pointer and `mem_wdata_o` equal to the difference. The pointer then reads as that value plus one, and 0xFFFF wraps to 0x0000.
- R3: Register and memory writes are never asserted together, and neither is asserted in a cycle unless an operation strobe was sampled on the previous edge.
- R4: `flag_n_o` equals bit 7 of the last difference, and `flag_z_o` is 1 exactly when all eight bits of the difference are 0.
- R5: `flag_c_o` is 1 when the source value is greater than or equal to the accumulator as unsigned numbers (no borrow), and 0 when a borrow occurs.
- R6: `flag_v_o` is 1 exactly when the two operands differ in sign and the difference's sign differs from the source register's sign.
- R7: There are two accumulators. `acc_wr_i` loads `acc_wr_data_i` into the active one only, `xchg_i` toggles `bank_o`, and a subtraction always uses the accumulator of the current bank.
- R8: If a strobe coincides with an exchange or an accumulator load, the subtraction uses the bank and accumulator value from before that edge.
- R9: `idx_wr_i` loads `idx_wr_data_i` into the index pointer, and it takes precedence over a post-write increment in the same cycle.
- R10: After reset both accumulators, the bank, the index pointer, the flags and both write strobes are 0.
- R11: The flags hold their value in every cycle that follows an edge without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| op_go_i | input | 1 | Operation strobe |
| src_sel_i | input | 5 | Source register selector |
| dst_sel_i | input | 5 | Destination register selector |
| dst_mem_i | input | 1 | 1: write to memory at index pointer, 0: write to register |
| xchg_i | input | 1 | Bank exchange command |
| acc_wr_i | input | 1 | Load active accumulator |
| acc_wr_data_i | input | 8 | Accumulator load value |
| idx_wr_i | input | 1 | Load index pointer |
| idx_wr_data_i | input | 16 | Index pointer load value |
| rf_rdata_i | input | 8 | Register-file read data for `rf_raddr_o` |
| rf_raddr_o | output | 5 | Register-file read address (follows `src_sel_i`) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Register-file write address |
| rf_wdata_o | output | 8 | Register-file write data |
| mem_we_o | output | 1 | Data-memory write enable |
| mem_addr_o | output | 16 | Data-memory write address |
| mem_wdata_o | output | 8 | Data-memory write data |
| idx_o | output | 16 | Current index pointer |
| bank_o | output | 1 | Active bank |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry (no-borrow) flag |
| flag_v_o | output | 1 | Overflow flag |

## Verification
Every cycle, the assertions check several properties. The two write strobes must be exclusive, and each must be caused by a strobe on the previous edge. Negative and zero must agree with the written data. A memory write must leave the pointer one past the address used. An exchange must toggle the bank, and the flags must stay frozen when no strobe occurs. Some behaviour is only visible in the bench's scenarios, where its reference model is compared on every clock. This covers the arithmetic value, carry and overflow against hidden accumulator contents. It also covers the accumulator loads landing in the correct bank, the ordering when a strobe coincides with an exchange, an accumulator load or a pointer load, and the pointer wrapping at 0xFFFF.

// File: rtl/bsub_pkg.sv
package bsub_pkg;
    parameter int unsigned DATA_W   = 8;
    parameter int unsigned REGS     = 32;
    parameter int unsigned IDX_W    = 16;
    parameter int unsigned NUM_BANK = 2;

    localparam int unsigned SEL_W  = $clog2(REGS);
    localparam int unsigned BANK_W = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [BANK_W-1:0] bank_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic   rf_we;
        sel_t   rf_waddr;
        data_t  rf_wdata;
        logic   mem_we;
        idx_t   mem_addr;
        data_t  mem_wdata;
        flags_t flags;
    } exec_state_t;
endpackage

// File: rtl/bsub_acc_bank.sv
module bsub_acc_bank
    import bsub_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  xchg_i,
    input  logic  wr_i,
    input  data_t wr_data_i,
    output data_t active_o,
    output bank_t bank_o
);
    data_t acc_d [NUM_BANK];
    data_t acc_q [NUM_BANK];
    bank_t bank_d, bank_q;

    always_comb begin
        if (!xchg_i) begin
            bank_d = bank_q;
        end else if (32'(bank_q) == NUM_BANK - 1) begin
            bank_d = '0;
        end else begin
            bank_d = bank_q + bank_t'(1);
        end
    end

    for (genvar g = 0; g < NUM_BANK; g++) begin : g_acc
        always_comb begin
            acc_d[g] = acc_q[g];
            if (wr_i && (32'(bank_q) == g)) begin
                acc_d[g] = wr_data_i;
            end
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                acc_q[g] <= '0;
            end else begin
                acc_q[g] <= acc_d[g];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign active_o = acc_q[bank_q];
    assign bank_o   = bank_q;
endmodule

// File: rtl/bsub_alu.sv
module bsub_alu
    import bsub_pkg::*;
(
    input  data_t  minuend_i,
    input  data_t  subtrahend_i,
    output data_t  diff_o,
    output flags_t flags_o
);
    logic [DATA_W:0] wide;

    always_comb begin
        wide       = {1'b0, minuend_i} - {1'b0, subtrahend_i};
        diff_o     = wide[DATA_W-1:0];
        flags_o.n  = wide[DATA_W-1];
        flags_o.z  = (wide[DATA_W-1:0] == '0);
        flags_o.c  = ~wide[DATA_W];
        flags_o.v  = (minuend_i[DATA_W-1] ^ subtrahend_i[DATA_W-1])
                   & (minuend_i[DATA_W-1] ^ wide[DATA_W-1]);
    end
endmodule

// File: rtl/bsub_idx_ptr.sv
module bsub_idx_ptr
    import bsub_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  idx_t load_data_i,
    input  logic bump_i,
    output idx_t idx_o
);
    idx_t idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (load_i) begin
            idx_d = load_data_i;
        end else if (bump_i) begin
            idx_d = idx_q + idx_t'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    assign idx_o = idx_q;
endmodule

// File: rtl/bsub_exec_unit.sv
module bsub_exec_unit
    import bsub_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        op_go_i,
    input  logic [4:0]  src_sel_i,
    input  logic [4:0]  dst_sel_i,
    input  logic        dst_mem_i,
    input  logic        xchg_i,
    input  logic        acc_wr_i,
    input  logic [7:0]  acc_wr_data_i,
    input  logic        idx_wr_i,
    input  logic [15:0] idx_wr_data_i,
    input  logic [7:0]  rf_rdata_i,
    output logic [4:0]  rf_raddr_o,
    output logic        rf_we_o,
    output logic [4:0]  rf_waddr_o,
    output logic [7:0]  rf_wdata_o,
    output logic        mem_we_o,
    output logic [15:0] mem_addr_o,
    output logic [7:0]  mem_wdata_o,
    output logic [15:0] idx_o,
    output logic        bank_o,
    output logic        flag_n_o,
    output logic        flag_z_o,
    output logic        flag_c_o,
    output logic        flag_v_o
);
    exec_state_t st_d, st_q;
    data_t       acc_active;
    bank_t       bank_cur;
    data_t       diff;
    flags_t      flags_new;
    idx_t        idx_cur;
    logic        bump;

    bsub_acc_bank u_acc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .xchg_i    (xchg_i),
        .wr_i      (acc_wr_i),
        .wr_data_i (acc_wr_data_i),
        .active_o  (acc_active),
        .bank_o    (bank_cur)
    );

    bsub_alu u_alu (
        .minuend_i    (rf_rdata_i),
        .subtrahend_i (acc_active),
        .diff_o       (diff),
        .flags_o      (flags_new)
    );

    assign bump = op_go_i & dst_mem_i;

    bsub_idx_ptr u_idx (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (idx_wr_i),
        .load_data_i (idx_wr_data_i),
        .bump_i      (bump),
        .idx_o       (idx_cur)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rf_we  = 1'b0;
        st_d.mem_we = 1'b0;
        if (op_go_i) begin
            st_d.flags = flags_new;
            if (dst_mem_i) begin
                st_d.mem_we    = 1'b1;
                st_d.mem_addr  = idx_cur;
                st_d.mem_wdata = diff;
            end else begin
                st_d.rf_we    = 1'b1;
                st_d.rf_waddr = dst_sel_i;
                st_d.rf_wdata = diff;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rf_raddr_o  = src_sel_i;
    assign rf_we_o     = st_q.rf_we;
    assign rf_waddr_o  = st_q.rf_waddr;
    assign rf_wdata_o  = st_q.rf_wdata;
    assign mem_we_o    = st_q.mem_we;
    assign mem_addr_o  = st_q.mem_addr;
    assign mem_wdata_o = st_q.mem_wdata;
    assign idx_o       = idx_cur;
    assign bank_o      = bank_cur[0];
    assign flag_n_o    = st_q.flags.n;
    assign flag_z_o    = st_q.flags.z;
    assign flag_c_o    = st_q.flags.c;
    assign flag_v_o    = st_q.flags.v;
endmodule

// File: rtl/bsub_exec_chk.sv
module bsub_exec_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        op_go_i,
    input logic        xchg_i,
    input logic        idx_wr_i,
    input logic        rf_we_o,
    input logic [7:0]  rf_wdata_o,
    input logic        mem_we_o,
    input logic [15:0] mem_addr_o,
    input logic [7:0]  mem_wdata_o,
    input logic [15:0] idx_o,
    input logic        bank_o,
    input logic        flag_n_o,
    input logic        flag_z_o,
    input logic        flag_c_o,
    input logic        flag_v_o
);
    // R3
    write_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rf_we_o && mem_we_o));

    // R3
    write_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !op_go_i |=> (!rf_we_o && !mem_we_o));

    // R4
    rf_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rf_we_o |-> (flag_n_o == rf_wdata_o[7]) && (flag_z_o == (rf_wdata_o == 8'h00)));

    // R4
    mem_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> (flag_n_o == mem_wdata_o[7]) && (flag_z_o == (mem_wdata_o == 8'h00)));

    // R2
    idx_bump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_we_o && !$past(idx_wr_i)) |-> (idx_o == mem_addr_o + 16'd1));

    // R7
    bank_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xchg_i |=> (bank_o != $past(bank_o)));

    // R11
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !op_go_i |=> $stable({flag_n_o, flag_z_o, flag_c_o, flag_v_o}));
endmodule

bind bsub_exec_unit bsub_exec_chk chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_go_i     (op_go_i),
    .xchg_i      (xchg_i),
    .idx_wr_i    (idx_wr_i),
    .rf_we_o     (rf_we_o),
    .rf_wdata_o  (rf_wdata_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .idx_o       (idx_o),
    .bank_o      (bank_o),
    .flag_n_o    (flag_n_o),
    .flag_z_o    (flag_z_o),
    .flag_c_o    (flag_c_o),
    .flag_v_o    (flag_v_o)
);

// File: tb/bsub_exec_unit_tb.sv
module bsub_exec_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_go = 1'b0;
    logic [4:0]  src_sel = '0;
    logic [4:0]  dst_sel = '0;
    logic        dst_mem = 1'b0;
    logic        xchg = 1'b0;
    logic        acc_wr = 1'b0;
    logic [7:0]  acc_wr_data = '0;
    logic        idx_wr = 1'b0;
    logic [15:0] idx_wr_data = '0;
    logic [7:0]  rf_rdata;
    logic [4:0]  rf_raddr;
    logic        rf_we, mem_we, bank;
    logic [4:0]  rf_waddr;
    logic [7:0]  rf_wdata, mem_wdata;
    logic [15:0] mem_addr, idx;
    logic        fn, fz, fc, fv;

    int unsigned regs [32];
    int unsigned m_acc [2];
    int unsigned m_bank, m_idx;
    int unsigned e_rf_we, e_rf_waddr, e_rf_wdata, e_mem_we, e_mem_addr, e_mem_wdata;
    int unsigned e_n, e_z, e_c, e_v;
    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign rf_rdata = 8'(regs[rf_raddr]);

    bsub_exec_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .op_go_i(op_go), .src_sel_i(src_sel),
        .dst_sel_i(dst_sel), .dst_mem_i(dst_mem), .xchg_i(xchg), .acc_wr_i(acc_wr),
        .acc_wr_data_i(acc_wr_data), .idx_wr_i(idx_wr), .idx_wr_data_i(idx_wr_data),
        .rf_rdata_i(rf_rdata), .rf_raddr_o(rf_raddr), .rf_we_o(rf_we),
        .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .idx_o(idx), .bank_o(bank),
        .flag_n_o(fn), .flag_z_o(fz), .flag_c_o(fc), .flag_v_o(fv)
    );

    task automatic cmp(input string tag, input int unsigned act, input int unsigned exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        cmp("R1/R3 rf_we", rf_we, e_rf_we);
        if (e_rf_we != 0) begin
            cmp("R1 rf_waddr", rf_waddr, e_rf_waddr);
            cmp("R1 rf_wdata", rf_wdata, e_rf_wdata);
        end
        cmp("R2/R3 mem_we", mem_we, e_mem_we);
        if (e_mem_we != 0) begin
            cmp("R2 mem_addr", mem_addr, e_mem_addr);
            cmp("R2 mem_wdata", mem_wdata, e_mem_wdata);
        end
        cmp("R2/R9 idx", idx, m_idx);
        cmp("R7 bank", bank, m_bank);
        cmp("R4 flag_n", fn, e_n);
        cmp("R4 flag_z", fz, e_z);
        cmp("R5 flag_c", fc, e_c);
        cmp("R6 flag_v", fv, e_v);
    endtask

    // Behavioural reference: advances on the edge using pre-edge state (R8).
    task automatic model_edge();
        int unsigned rs, a, d;
        rs = regs[src_sel];
        a  = m_acc[m_bank];
        e_rf_we  = 0;
        e_mem_we = 0;
        if (op_go) begin
            d   = (rs + 256 - a) % 256;
            e_n = (d >= 128) ? 1 : 0;
            e_z = (d == 0) ? 1 : 0;
            e_c = (rs >= a) ? 1 : 0;
            e_v = (((rs >= 128) != (a >= 128)) && ((d >= 128) != (rs >= 128))) ? 1 : 0;
            if (dst_mem) begin
                e_mem_we = 1; e_mem_addr = m_idx; e_mem_wdata = d;
            end else begin
                e_rf_we = 1; e_rf_waddr = dst_sel; e_rf_wdata = d;
            end
        end
        if (acc_wr) m_acc[m_bank] = acc_wr_data;
        if (idx_wr) m_idx = idx_wr_data;
        else if (op_go && dst_mem) m_idx = (m_idx + 1) % 65536;
        if (xchg) m_bank = 1 - m_bank;
    endtask

    task automatic step();
        @(posedge clk);
        cycles++;
        model_edge();
        @(negedge clk);
        compare_all();
        if (e_rf_we != 0) regs[e_rf_waddr] = e_rf_wdata;
        op_go = 0; xchg = 0; acc_wr = 0; idx_wr = 0; dst_mem = 0;
    endtask

    task automatic load_acc(input int unsigned v);
        acc_wr = 1; acc_wr_data = 8'(v); step();
    endtask

    task automatic sub(input int unsigned s, input int unsigned d, input bit to_mem);
        op_go = 1; src_sel = 5'(s); dst_sel = 5'(d); dst_mem = to_mem; step();
    endtask

    initial begin
        int unsigned lfsr;
        for (int i = 0; i < 32; i++) regs[i] = (i * 37 + 11) % 256;
        m_acc[0] = 0; m_acc[1] = 0; m_bank = 0; m_idx = 0;
        e_rf_we = 0; e_mem_we = 0; e_n = 0; e_z = 0; e_c = 0; e_v = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare_all();                              // R10 reset state
        step();                                     // R11 idle: flags hold
        // Constant 4 into accumulator, r20=10 -> r21 gets 6 (R1)
        regs[20] = 10;
        load_acc(4);
        sub(20, 21, 0);
        step();
        cmp("R1 reg21 value", regs[21], 6);
        // Borrow and negative: 0 - 1 (R5, R4)
        regs[3] = 0; load_acc(1); sub(3, 4, 0);
        // Signed overflow: 0x80 - 1 (R6)
        regs[5] = 8'h80; sub(5, 6, 0);
        // 0x7F - 0xFF overflow with borrow (R6, R5)
        regs[7] = 8'h7F; load_acc(8'hFF); sub(7, 8, 0);
        // Equal -> zero with carry (R4, R5)
        regs[9] = 8'hFF; sub(9, 10, 0);
        // Bank B, separate accumulator (R7)
        xchg = 1; step();
        load_acc(3); sub(20, 22, 0);
        xchg = 1; step();
        sub(20, 23, 0);                             // back to bank A value 0xFF
        // Memory mode with wrap (R2)
        idx_wr = 1; idx_wr_data = 16'hFFFE; step();
        sub(20, 0, 1); sub(9, 0, 1); sub(3, 0, 1);
        // Strobe with exchange and accumulator load same edge (R8)
        op_go = 1; src_sel = 5'd20; dst_sel = 5'd24; xchg = 1; acc_wr = 1; acc_wr_data = 8'h55; step();
        sub(20, 25, 0);
        // Pointer load beats increment (R9)
        op_go = 1; src_sel = 5'd20; dst_mem = 1; idx_wr = 1; idx_wr_data = 16'h1234; step();
        sub(20, 0, 1);
        // Pseudo-random mix of all controls
        lfsr = 32'hACE1;
        for (int k = 0; k < 400; k++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
            op_go = lfsr[0]; src_sel = 5'(lfsr >> 1); dst_sel = 5'(lfsr >> 6);
            dst_mem = lfsr[11]; xchg = (lfsr[12] & lfsr[13]);
            acc_wr = lfsr[14]; acc_wr_data = 8'(lfsr >> 3);
            idx_wr = (lfsr[2] & lfsr[9] & lfsr[15]); idx_wr_data = 16'(lfsr * 7);
            step();
        end
        repeat (3) step();                          // R11 hold after traffic
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule